// File: doc/BRIEF.md
# Multi-layer AHB-Lite crossbar

This block connects a set of AHB-Lite masters to a set of AHB-Lite slaves so that every master behaves as the sole master on its own bus layer. Each master port decodes the address of its current transfer against a per-slave base and mask and directs the transfer to one slave. Each slave port has its own round-robin arbiter and multiplexer, so masters that target different slaves are served in the same cycle. Only a clash on one slave makes a master wait.

Masters have no request or grant wires. A master simply drives a transfer. When the target slave is busy with another master, the fabric captures the address phase in a holding register on that master's port and drives the master's HREADY low until the slave takes it. The fabric remembers which slave owns each master's data phase. It uses that record to route read data, ready and response back to the master, and to steer the master's write data to the slave. A slave is never taken from a master in the middle of its burst. Addresses that match no slave are answered by an error responder built into each master port.

Top module: `ahbx_xbar`

## Requirements
- R1: A NONSEQ, SEQ or BUSY transfer whose address satisfies (addr & MASK[s]) == BASE[s] is forwarded to slave s only, with HSEL high and the same address, HWRITE, HSIZE and HBURST. HTRANS is encoded IDLE=0, BUSY=1, NONSEQ=2, SEQ=3.
- R2: Two masters that start transfers to different slaves in the same cycle both have their address phases accepted at that edge. Both complete after the slave's own wait states, with no extra cycle.
- R3: A master whose transfer targets a slave granted to another master sees HREADY low until the slave takes the held transfer. The held transfer reaches the slave with its original address and attributes, and its data phase then takes one extra cycle when the slave has no wait states.
- R4: When several masters request one slave at a transfer boundary, the grant goes to the first requesting master after the last master that slave served, in ascending index order with wrap-around.
- R5: While the master last served by a slave presents SEQ or BUSY to it, that slave stays granted to that master. A fixed-length burst therefore runs its beats in consecutive cycles, and a competing master is served in the cycle after the last beat completes.
- R6: During a master's data phase with slave s, that master's HRDATA, HREADY and HRESP follow slave s, and slave s receives that master's HWDATA. HRESP is encoded OKAY=0, ERROR=1.
- R7: A NONSEQ or SEQ transfer that matches no slave is answered with ERROR over two cycles: HREADY low in the first and high in the second, with HRESP 1 in both. An unmatched IDLE or BUSY completes with zero-wait OKAY. In neither case is any slave selected.
- R8: During reset every master port shows HREADY 1 and HRESP 0, and no slave has HSEL high.
- R9: An IDLE transfer is never forwarded: no slave sees HSEL high because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_haddr | input | NM*AW | Master addresses, master m in bits m*AW +: AW |
| m_htrans | input | NM*2 | Master transfer types |
| m_hwrite | input | NM | Master write flags |
| m_hsize | input | NM*3 | Master transfer sizes |
| m_hburst | input | NM*3 | Master burst types |
| m_hwdata | input | NM*DW | Master write data |
| m_hrdata | output | NM*DW | Read data returned to each master |
| m_hready | output | NM | Ready returned to each master |
| m_hresp | output | NM | Response returned to each master |
| s_hsel | output | NS | Slave selects |
| s_haddr | output | NS*AW | Slave addresses |
| s_htrans | output | NS*2 | Slave transfer types |
| s_hwrite | output | NS | Slave write flags |
| s_hsize | output | NS*3 | Slave transfer sizes |
| s_hburst | output | NS*3 | Slave burst types |
| s_hwdata | output | NS*DW | Write data to each slave |
| s_hrdata | input | NS*DW | Slave read data |
| s_hreadyout | input | NS | Slave ready (each slave also samples its own address phase on it) |
| s_hresp | input | NS | Slave responses |

## Verification
The bench builds the crossbar with two masters and two slaves. The slaves are mapped on the top address nibble, and every address with a nibble of 2 or above falls to the error responder. This small setup makes a full sweep over master, slave, direction and slave wait states of 0, 1 and 2 cheap. It also covers every arbitration case: both round-robin orders, a hold against a single transfer, and a hold against a four-beat burst. Behavioural slave models return address-derived read data and log write data, so every expected value is computed from the address.

// File: rtl/ahbx_pkg.sv
package ahbx_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef struct packed {
        trans_e     trans;
        logic       write;
        logic [2:0] size;
        logic [2:0] burst;
    } ctl_t;

    typedef enum logic [2:0] {
        MP_IDLE = 3'd0,
        MP_HOLD = 3'd1,
        MP_DATA = 3'd2,
        MP_ERR1 = 3'd3,
        MP_ERR2 = 3'd4
    } mpmode_e;

    localparam ctl_t CTL_IDLE = '{trans: TR_IDLE, write: 1'b0, size: 3'd0, burst: 3'd0};

endpackage

// File: rtl/ahbx_decode.sv
module ahbx_decode #(
    parameter int NS = 2,
    parameter int AW = 32,
    parameter int SW = 1,
    parameter logic [NS*AW-1:0] BASE = '0,
    parameter logic [NS*AW-1:0] MASK = '0
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o,
    output logic [SW-1:0] sel_o
);
    logic [NS-1:0] match;

    for (genvar s = 0; s < NS; s++) begin : g_match
        assign match[s] = ((addr_i & MASK[s*AW +: AW]) == BASE[s*AW +: AW]);
    end

    // lowest matching index wins
    always_comb begin
        hit_o = 1'b0;
        sel_o = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (match[s]) begin
                hit_o = 1'b1;
                sel_o = SW'(s);
            end
        end
    end
endmodule

// File: rtl/ahbx_mport.sv
module ahbx_mport
    import ahbx_pkg::*;
#(
    parameter int NS = 2,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 1,
    parameter logic [NS*AW-1:0] BASE = '0,
    parameter logic [NS*AW-1:0] MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   haddr_i,
    input  ctl_t            ctl_i,
    output logic            hready_o,
    output logic            hresp_o,
    output logic [DW-1:0]   hrdata_o,
    output logic [NS-1:0]   req_o,
    output logic [AW-1:0]   addr_o,
    output ctl_t            ctl_o,
    input  logic [NS-1:0]   gnt_i,
    input  logic [NS-1:0]   s_ready_i,
    input  logic [NS-1:0]   s_resp_i,
    input  logic [NS*DW-1:0] s_rdata_i
);
    typedef struct packed {
        mpmode_e       mode;
        logic [SW-1:0] sel;
        logic [AW-1:0] addr;
        ctl_t          ctl;
    } mst_t;

    mst_t          st_d, st_q;
    logic          hit;
    logic [SW-1:0] dsel;
    logic          live_act, live_err, issue;

    ahbx_decode #(.NS(NS), .AW(AW), .SW(SW), .BASE(BASE), .MASK(MASK)) i_dec (
        .addr_i (haddr_i),
        .hit_o  (hit),
        .sel_o  (dsel)
    );

    // response towards the master
    always_comb begin
        hready_o = 1'b1;
        hresp_o  = 1'b0;
        hrdata_o = '0;
        case (st_q.mode)
            MP_HOLD: hready_o = 1'b0;
            MP_DATA: begin
                hready_o = s_ready_i[st_q.sel];
                hresp_o  = s_resp_i[st_q.sel];
                hrdata_o = s_rdata_i[int'(st_q.sel)*DW +: DW];
            end
            MP_ERR1: begin
                hready_o = 1'b0;
                hresp_o  = 1'b1;
            end
            MP_ERR2: hresp_o = 1'b1;
            default: ;
        endcase
    end

    // request towards the slaves: held transfer first, live bus otherwise
    always_comb begin
        live_act = hready_o && (ctl_i.trans != TR_IDLE);
        live_err = hready_o && !hit && (ctl_i.trans == TR_NSEQ || ctl_i.trans == TR_SEQ);
        req_o    = '0;
        if (st_q.mode == MP_HOLD) begin
            req_o[st_q.sel] = 1'b1;
            addr_o          = st_q.addr;
            ctl_o           = st_q.ctl;
        end else begin
            addr_o = haddr_i;
            ctl_o  = ctl_i;
            if (live_act && hit) begin
                req_o[dsel] = 1'b1;
            end
        end
        issue = |(req_o & gnt_i & s_ready_i);
    end

    always_comb begin
        st_d = st_q;
        case (st_q.mode)
            MP_HOLD: if (issue) st_d.mode = MP_DATA;
            MP_ERR1: st_d.mode = MP_ERR2;
            default: begin
                if (hready_o) begin
                    if (live_err) begin
                        st_d.mode = MP_ERR1;
                    end else if (|req_o) begin
                        st_d.sel  = dsel;
                        st_d.addr = haddr_i;
                        st_d.ctl  = ctl_i;
                        st_d.mode = issue ? MP_DATA : MP_HOLD;
                    end else begin
                        st_d.mode = MP_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    dflt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_err |=> (!hready_o && hresp_o));

    // R3
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_o && (|req_o) && !issue) |=> !hready_o);

    // R6
    route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (hready_o == s_ready_i[st_q.sel]));
endmodule

// File: rtl/ahbx_sport.sv
module ahbx_sport
    import ahbx_pkg::*;
#(
    parameter int NM = 2,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int MW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    req_i,
    input  logic [NM*AW-1:0] addr_i,
    input  ctl_t             ctl_i [NM],
    input  logic [NM*DW-1:0] wdata_i,
    input  logic             s_ready_i,
    output logic [NM-1:0]    gnt_o,
    output logic             hsel_o,
    output logic [AW-1:0]    haddr_o,
    output ctl_t             ctl_o,
    output logic [DW-1:0]    hwdata_o
);
    typedef struct packed {
        logic [MW-1:0] own;
        logic          dpv;
        logic [MW-1:0] dpm;
    } sst_t;

    sst_t          st_d, st_q;
    logic [MW-1:0] win;
    logic          lock;
    int            idx;

    // round-robin pick, frozen while the last owner continues a burst
    always_comb begin
        lock = req_i[st_q.own] &&
               (ctl_i[st_q.own].trans == TR_SEQ || ctl_i[st_q.own].trans == TR_BUSY);
        win  = st_q.own;
        idx  = 0;
        if (!lock) begin
            for (int k = NM; k >= 1; k--) begin
                idx = (int'(st_q.own) + k) % NM;
                if (req_i[idx]) win = MW'(idx);
            end
        end
        gnt_o      = '0;
        gnt_o[win] = req_i[win];
        hsel_o     = req_i[win];
        haddr_o    = addr_i[int'(win)*AW +: AW];
        ctl_o      = req_i[win] ? ctl_i[win] : CTL_IDLE;
        hwdata_o   = wdata_i[int'(st_q.dpm)*DW +: DW];
    end

    always_comb begin
        st_d = st_q;
        if (s_ready_i) begin
            st_d.dpv = hsel_o;
            if (hsel_o) begin
                st_d.own = win;
                st_d.dpm = win;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready_i && hsel_o && ctl_o.trans == TR_SEQ && st_q.dpv) |-> (win == st_q.dpm));
endmodule

// File: rtl/ahbx_xbar.sv
module ahbx_xbar
    import ahbx_pkg::*;
#(
    parameter int NM = 2,
    parameter int NS = 2,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter logic [NS*AW-1:0] SBASE = {32'h1000_0000, 32'h0000_0000},
    parameter logic [NS*AW-1:0] SMASK = {32'hF000_0000, 32'hF000_0000}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM*AW-1:0] m_haddr,
    input  logic [NM*2-1:0]  m_htrans,
    input  logic [NM-1:0]    m_hwrite,
    input  logic [NM*3-1:0]  m_hsize,
    input  logic [NM*3-1:0]  m_hburst,
    input  logic [NM*DW-1:0] m_hwdata,
    output logic [NM*DW-1:0] m_hrdata,
    output logic [NM-1:0]    m_hready,
    output logic [NM-1:0]    m_hresp,
    output logic [NS-1:0]    s_hsel,
    output logic [NS*AW-1:0] s_haddr,
    output logic [NS*2-1:0]  s_htrans,
    output logic [NS-1:0]    s_hwrite,
    output logic [NS*3-1:0]  s_hsize,
    output logic [NS*3-1:0]  s_hburst,
    output logic [NS*DW-1:0] s_hwdata,
    input  logic [NS*DW-1:0] s_hrdata,
    input  logic [NS-1:0]    s_hreadyout,
    input  logic [NS-1:0]    s_hresp
);
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;
    localparam int MW = (NM > 1) ? $clog2(NM) : 1;

    ctl_t                   min_ctl [NM];
    ctl_t                   mctl    [NM];
    ctl_t                   sctl    [NS];
    logic [NM*AW-1:0]       maddr;
    logic [NM-1:0][NS-1:0]  mreq, mgnt;
    logic [NS-1:0][NM-1:0]  sreq, sgnt;

    for (genvar m = 0; m < NM; m++) begin : g_mst
        assign min_ctl[m] = ctl_t'({m_htrans[2*m +: 2], m_hwrite[m],
                                    m_hsize[3*m +: 3], m_hburst[3*m +: 3]});

        ahbx_mport #(.NS(NS), .AW(AW), .DW(DW), .SW(SW), .BASE(SBASE), .MASK(SMASK)) i_mport (
            .clk       (clk),
            .rst_n     (rst_n),
            .haddr_i   (m_haddr[m*AW +: AW]),
            .ctl_i     (min_ctl[m]),
            .hready_o  (m_hready[m]),
            .hresp_o   (m_hresp[m]),
            .hrdata_o  (m_hrdata[m*DW +: DW]),
            .req_o     (mreq[m]),
            .addr_o    (maddr[m*AW +: AW]),
            .ctl_o     (mctl[m]),
            .gnt_i     (mgnt[m]),
            .s_ready_i (s_hreadyout),
            .s_resp_i  (s_hresp),
            .s_rdata_i (s_hrdata)
        );

        for (genvar s = 0; s < NS; s++) begin : g_x
            assign sreq[s][m] = mreq[m][s];
            assign mgnt[m][s] = sgnt[s][m];
        end

        // R1
        gnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(mgnt[m]));
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        ahbx_sport #(.NM(NM), .AW(AW), .DW(DW), .MW(MW)) i_sport (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (sreq[s]),
            .addr_i    (maddr),
            .ctl_i     (mctl),
            .wdata_i   (m_hwdata),
            .s_ready_i (s_hreadyout[s]),
            .gnt_o     (sgnt[s]),
            .hsel_o    (s_hsel[s]),
            .haddr_o   (s_haddr[s*AW +: AW]),
            .ctl_o     (sctl[s]),
            .hwdata_o  (s_hwdata[s*DW +: DW])
        );
        assign s_htrans[2*s +: 2] = sctl[s].trans;
        assign s_hwrite[s]        = sctl[s].write;
        assign s_hsize[3*s +: 3]  = sctl[s].size;
        assign s_hburst[3*s +: 3] = sctl[s].burst;
    end
endmodule

// File: tb/test_ahbx_xbar.sv
module test_ahbx_xbar;
    localparam int TCK = 10;
    localparam int NM  = 2;
    localparam int NS  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(TCK/2) clk = ~clk;

    logic [NM*32-1:0] m_haddr, m_hwdata, m_hrdata;
    logic [NM*2-1:0]  m_htrans;
    logic [NM-1:0]    m_hwrite, m_hready, m_hresp;
    logic [NM*3-1:0]  m_hsize, m_hburst;
    logic [NS-1:0]    s_hsel, s_hwrite, s_hreadyout, s_hresp;
    logic [NS*32-1:0] s_haddr, s_hwdata, s_hrdata;
    logic [NS*2-1:0]  s_htrans;
    logic [NS*3-1:0]  s_hsize, s_hburst;

    ahbx_xbar #(.NM(NM), .NS(NS)) i_ahbx_xbar (
        .clk(clk), .rst_n(rst_n),
        .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
        .m_hburst(m_hburst), .m_hwdata(m_hwdata), .m_hrdata(m_hrdata), .m_hready(m_hready),
        .m_hresp(m_hresp), .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans),
        .s_hwrite(s_hwrite), .s_hsize(s_hsize), .s_hburst(s_hburst), .s_hwdata(s_hwdata),
        .s_hrdata(s_hrdata), .s_hreadyout(s_hreadyout), .s_hresp(s_hresp)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] salt(input int s);
        return 32'hA5A5_0000 | 32'(s);
    endfunction

    // behavioural slaves: wait states from wst, read data = address ^ salt
    int wst [NS];
    logic [NS-1:0][31:0] wla_v, wld_v;
    logic [NS-1:0][31:0] acc_v;

    for (genvar s = 0; s < NS; s++) begin : g_sl
        logic        act, wr;
        logic [31:0] a, la, ld, acc;
        int          cnt;
        assign s_hreadyout[s]      = !act || cnt == 0;
        assign s_hresp[s]          = 1'b0;
        assign s_hrdata[s*32 +: 32] = act ? (a ^ salt(s)) : 32'h0;
        assign wla_v[s] = la;
        assign wld_v[s] = ld;
        assign acc_v[s] = acc;
        always @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act <= 1'b0; cnt <= 0; wr <= 1'b0; a <= '0;
                la <= '0; ld <= '0; acc <= '0;
            end else if (s_hreadyout[s]) begin
                if (act && wr) begin
                    la <= a;
                    ld <= s_hwdata[s*32 +: 32];
                end
                if (s_hsel[s] && s_htrans[2*s+1]) begin
                    act <= 1'b1;
                    a   <= s_haddr[s*32 +: 32];
                    wr  <= s_hwrite[s];
                    cnt <= wst[s];
                    acc <= acc + 1;
                end else begin
                    act <= 1'b0;
                end
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    logic [31:0] rd [NM][8];
    logic        rs [NM][8];
    int          dn [NM][8];
    int          ac [NM];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // pipelined driver; call at a falling edge, returns at a falling edge
    task automatic run(input int m, input logic [31:0] a0, input int n,
                       input logic wr, input logic [31:0] wd0);
        for (int i = 0; i <= n; i++) begin
            if (i < n) begin
                m_haddr[m*32 +: 32] = a0 + 32'(4*i);
                m_htrans[2*m +: 2]  = (i == 0) ? 2'b10 : 2'b11;
                m_hburst[3*m +: 3]  = (n == 1) ? 3'b000 : 3'b011;
                m_hsize[3*m +: 3]   = 3'b010;
                m_hwrite[m]         = wr;
            end else begin
                m_htrans[2*m +: 2]  = 2'b00;
            end
            if (i > 0) m_hwdata[m*32 +: 32] = wd0 + 32'(i-1);
            #(TCK/4);
            while (!m_hready[m]) begin
                @(negedge clk);
                #(TCK/4);
            end
            if (i == 0) begin
                ac[m] = cyc;
            end else begin
                rd[m][i-1] = m_hrdata[m*32 +: 32];
                rs[m][i-1] = m_hresp[m];
                dn[m][i-1] = cyc;
            end
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected done", cyc);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a, wd, acc0;
        m_haddr = '0; m_htrans = '0; m_hwrite = '0; m_hsize = '0; m_hburst = '0; m_hwdata = '0;
        wst[0] = 0; wst[1] = 0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 hready", 32'(m_hready), 32'h3);
        chk("R8 hresp", 32'(m_hresp), 32'h0);
        chk("R8 hsel", 32'(s_hsel), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 idle on mapped addresses
        m_haddr = {32'h1000_0010, 32'h0000_0010};
        m_htrans = '0;
        #(TCK/4);
        chk("R9 hsel", 32'(s_hsel), 32'h0);
        @(negedge clk);

        // R1 R6 sweep: master x slave x wait x direction
        for (int m = 0; m < NM; m++) begin
            for (int s = 0; s < NS; s++) begin
                for (int w = 0; w < 3; w++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        wst[s] = w;
                        a  = 32'h1000_0000 * 32'(s) + 32'h100 + 32'(m*64 + w*16 + wr*4);
                        wd = 32'hD000_0000 ^ a;
                        run(m, a, 1, wr[0], wd);
                        if (wr == 0) begin
                            chk("R1 read data", rd[m][0], a ^ salt(s));
                        end else begin
                            chk("R6 write addr", wla_v[s], a);
                            chk("R6 write data", wld_v[s], wd);
                        end
                        chk("R6 resp", 32'(rs[m][0]), 32'h0);
                        chk("R6 latency", 32'(dn[m][0] - ac[m]), 32'(1 + w));
                    end
                end
            end
        end
        wst[0] = 0; wst[1] = 0;

        // R7 unmatched NONSEQ then unmatched BUSY
        acc0 = acc_v[0] + acc_v[1];
        m_haddr[31:0] = 32'h2000_0000;
        m_htrans[1:0] = 2'b10;
        #(TCK/4);
        chk("R7 addr ready", 32'(m_hready[0]), 32'h1);
        chk("R7 no hsel", 32'(s_hsel), 32'h0);
        @(negedge clk);
        m_htrans[1:0] = 2'b00;
        #(TCK/4);
        chk("R7 err1 ready", 32'(m_hready[0]), 32'h0);
        chk("R7 err1 resp", 32'(m_hresp[0]), 32'h1);
        @(negedge clk);
        #(TCK/4);
        chk("R7 err2 ready", 32'(m_hready[0]), 32'h1);
        chk("R7 err2 resp", 32'(m_hresp[0]), 32'h1);
        @(negedge clk);
        #(TCK/4);
        chk("R7 after resp", 32'(m_hresp[0]), 32'h0);
        @(negedge clk);
        m_htrans[1:0] = 2'b01;
        #(TCK/4);
        chk("R7 busy no hsel", 32'(s_hsel), 32'h0);
        @(negedge clk);
        m_htrans[1:0] = 2'b00;
        #(TCK/4);
        chk("R7 busy ready", 32'(m_hready[0]), 32'h1);
        chk("R7 busy resp", 32'(m_hresp[0]), 32'h0);
        chk("R7 no slave access", acc_v[0] + acc_v[1], acc0);
        @(negedge clk);

        // R2 concurrent masters on different slaves
        fork
            run(0, 32'h0000_0600, 1, 1'b0, 32'h0);
            run(1, 32'h1000_0600, 1, 1'b0, 32'h0);
        join
        chk("R2 same accept", 32'(ac[0]), 32'(ac[1]));
        chk("R2 m0 latency", 32'(dn[0][0] - ac[0]), 32'h1);
        chk("R2 m1 latency", 32'(dn[1][0] - ac[1]), 32'h1);
        chk("R2 m0 data", rd[0][0], 32'h0000_0600 ^ salt(0));
        chk("R2 m1 data", rd[1][0], 32'h1000_0600 ^ salt(1));

        // R4 after master 1 was served, master 0 wins; R3 master 1 held
        run(1, 32'h0000_0700, 1, 1'b0, 32'h0);
        fork
            run(0, 32'h0000_0200, 1, 1'b1, 32'h1111_0000);
            run(1, 32'h0000_0300, 1, 1'b0, 32'h0);
        join
        chk("R4 m0 wins", 32'(dn[0][0] - ac[0]), 32'h1);
        chk("R3 m1 held", 32'(dn[1][0] - ac[1]), 32'h2);
        chk("R3 held addr", rd[1][0], 32'h0000_0300 ^ salt(0));
        chk("R6 m0 wdata", wld_v[0], 32'h1111_0000);

        // R4 after master 0 was served, master 1 wins; R3 held write
        run(0, 32'h0000_0710, 1, 1'b0, 32'h0);
        fork
            run(0, 32'h0000_0220, 1, 1'b1, 32'h2222_0000);
            run(1, 32'h0000_0330, 1, 1'b0, 32'h0);
        join
        chk("R4 m1 wins", 32'(dn[1][0] - ac[1]), 32'h1);
        chk("R3 m0 held", 32'(dn[0][0] - ac[0]), 32'h2);
        chk("R3 held write addr", wla_v[0], 32'h0000_0220);
        chk("R3 held write data", wld_v[0], 32'h2222_0000);

        // R5 burst keeps the slave
        fork
            run(0, 32'h0000_0400, 4, 1'b0, 32'h0);
            begin
                @(negedge clk);
                run(1, 32'h0000_0500, 1, 1'b0, 32'h0);
            end
        join
        chk("R5 beats back to back", 32'(dn[0][3] - ac[0]), 32'h4);
        for (int i = 0; i < 4; i++) begin
            chk("R5 beat data", rd[0][i], (32'h0000_0400 + 32'(4*i)) ^ salt(0));
        end
        chk("R5 waiter after burst", 32'(dn[1][0]), 32'(dn[0][3] + 1));
        chk("R5 waiter data", rd[1][0], 32'h0000_0500 ^ salt(0));

        summary();
        $finish;
    end
endmodule